// File: doc/BRIEF.md
# AXI Decode-Error Responder

This block is the endpoint a router uses for requests whose address matched no routing rule. It behaves as a full AXI4 subordinate on the AW, W, B, AR and R channels, but it holds no storage. Each write is taken in whole: the block accepts every data beat up to the one marked last, then sends one write response with the decode-error code. Each read is answered with as many data beats as the burst length asks for. Every beat carries the decode-error code and a fixed filler word.

Requests wait in two small queues, one for writes and one for reads. The two directions run independently of each other. Within one direction, requests are answered in the order they arrived, and each response carries the ID of its request. The data port width is a parameter. The 32-bit filler word 0xBADCAB1E is padded with zeros or cut down to fit that width. Addresses and write data carry no information this block needs, so they are not ports. The surrounding fabric drives only the handshake, ID, length and last-beat signals.

Top module: `axi_decerr_sink`

## Requirements
- R1: While reset is high and in the first cycle after it, `b_valid`, `r_valid` and `w_ready` are 0, and `aw_ready` and `ar_ready` are 1.
- R2: Every write response carries `b_resp` = 2'b11 and every read beat carries `r_resp` = 2'b11 (decode error).
- R3: A read request with length field L returns exactly L+1 beats. `r_last` is 1 on the final beat only.
- R4: Every read beat has `r_data` equal to 32'hBADCAB1E, zero-extended when DATA_W > 32 and cut to its low DATA_W bits when DATA_W < 32.
- R5: A write response is raised in the cycle after a W beat with `w_last` = 1 is accepted, and never at any other time. There is one response per write.
- R6: `b_id` and `r_id` equal the ID of the request being answered.
- R7: Writes are answered in AW order and reads in AR order. Traffic in one direction never waits on the other.
- R8: `w_ready` is 1 exactly when an accepted write is still waiting for its last beat and no write response is pending. W beats that arrive before their AW are held off.
- R9: `aw_ready` is 1 exactly when fewer than DEPTH writes are waiting for their last beat. `ar_ready` is 1 whenever fewer than DEPTH reads are outstanding.
- R10: While `b_valid` or `r_valid` is high and its ready is low, the valid stays high and the ID, last flag and code do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write request valid |
| aw_ready | output | 1 | Write request accepted |
| aw_id | input | ID_W | Write request ID |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| w_last | input | 1 | Final beat of the write burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted |
| ar_id | input | ID_W | Read request ID |
| ar_len | input | LEN_W | Read burst length minus one |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |
| r_id | output | ID_W | Read beat ID |
| r_data | output | DATA_W | Read filler data |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat |

## Verification
Two read events can land on the same clock edge. One is the acceptance of the final beat of one burst. The other is the loading of the next queued read into the response stage. A new read request can also enter the queue on that same edge. The bench provokes this by queuing several reads, including zero-length ones, while `r_ready` is held high and later toggled at random. A behavioural model holds the expected beats in order, and the design must present each one with the right ID, last flag, code and filler. The write side is pushed into the matching case: the last W beat and the response handshake compete with a full request queue, and the expected states of `aw_ready`, `w_ready` and `b_valid` are compared on every clock.

// File: rtl/decerr_pkg.sv
package decerr_pkg;
  localparam logic [31:0] FILL_WORD   = 32'hBADCAB1E;
  localparam logic [1:0]  RESP_DECERR = 2'b11;
  localparam logic [1:0]  RESP_NONE   = 2'b00;
endpackage

// File: rtl/decerr_req_fifo.sv
module decerr_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = IW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[IW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
    end
  end

  assign dout  = mem[rd_ptr[IW-1:0]];
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[PW-1] != rd_ptr[PW-1]) && (wr_ptr[IW-1:0] == rd_ptr[IW-1:0]);

  // R7: the consumer never takes an entry that is not there
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R9: the producer never writes past capacity
  assert_push_nonfull_R9: assert property (@(posedge clk) disable iff (rst) push |-> !full);
endmodule

// File: rtl/decerr_wr_path.sv
module decerr_wr_path
  import decerr_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            aw_valid,
  output logic            aw_ready,
  input  logic [ID_W-1:0] aw_id,
  input  logic            w_valid,
  output logic            w_ready,
  input  logic            w_last,
  output logic            b_valid,
  input  logic            b_ready,
  output logic [ID_W-1:0] b_id,
  output logic [1:0]      b_resp
);
  logic            q_full, q_empty, q_push, q_pop;
  logic [ID_W-1:0] q_head;
  logic            bv_q;
  logic [ID_W-1:0] bid_q;
  logic [1:0]      bresp_q;

  decerr_req_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_awq (
    .clk(clk), .rst(rst), .push(q_push), .din(aw_id),
    .pop(q_pop), .dout(q_head), .full(q_full), .empty(q_empty)
  );

  assign aw_ready = !q_full;
  assign q_push   = aw_valid && !q_full;
  assign w_ready  = !q_empty && !bv_q;
  assign q_pop    = w_valid && w_ready && w_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      bv_q    <= 1'b0;
      bid_q   <= '0;
      bresp_q <= RESP_NONE;
    end else if (q_pop) begin
      bv_q    <= 1'b1;
      bid_q   <= q_head;
      bresp_q <= RESP_DECERR;
    end else if (bv_q && b_ready) begin
      bv_q <= 1'b0;
    end
  end

  assign b_valid = bv_q;
  assign b_id    = bid_q;
  assign b_resp  = bresp_q;

  assert_b_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(b_valid) |-> $past(w_valid && w_ready && w_last));
  assert_bresp_code_R2: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> b_resp == RESP_DECERR);
  assert_b_hold_R10: assert property (@(posedge clk) disable iff (rst)
    b_valid && !b_ready |=> b_valid && $stable(b_id) && $stable(b_resp));
endmodule

// File: rtl/decerr_rd_path.sv
module decerr_rd_path
  import decerr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  localparam int EW = ID_W + LEN_W;

  logic             q_full, q_empty, q_push, q_pop;
  logic [EW-1:0]    q_head;
  logic [ID_W-1:0]  head_id;
  logic [LEN_W-1:0] head_len;
  logic             rv_q, rlast_q;
  logic [ID_W-1:0]  rid_q;
  logic [LEN_W-1:0] rem_q;
  logic [1:0]       rresp_q;
  logic             beat_done, mid_beat;

  decerr_req_fifo #(.W(EW), .DEPTH(DEPTH)) u_arq (
    .clk(clk), .rst(rst), .push(q_push), .din({ar_id, ar_len}),
    .pop(q_pop), .dout(q_head), .full(q_full), .empty(q_empty)
  );

  assign {head_id, head_len} = q_head;
  assign ar_ready  = !q_full;
  assign q_push    = ar_valid && !q_full;
  assign beat_done = rv_q && r_ready;
  assign mid_beat  = beat_done && !rlast_q;
  assign q_pop     = !q_empty && (!rv_q || (beat_done && rlast_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q    <= 1'b0;
      rlast_q <= 1'b0;
      rid_q   <= '0;
      rem_q   <= '0;
      rresp_q <= RESP_NONE;
    end else if (mid_beat) begin
      rem_q   <= rem_q - LEN_W'(1);
      rlast_q <= (rem_q == LEN_W'(1));
    end else if (q_pop) begin
      rv_q    <= 1'b1;
      rid_q   <= head_id;
      rem_q   <= head_len;
      rlast_q <= (head_len == '0);
      rresp_q <= RESP_DECERR;
    end else if (beat_done) begin
      rv_q <= 1'b0;
    end
  end

  generate
    if (DATA_W > 32) begin : g_wide
      assign r_data = {{(DATA_W-32){1'b0}}, FILL_WORD};
    end else if (DATA_W == 32) begin : g_exact
      assign r_data = FILL_WORD;
    end else begin : g_narrow
      assign r_data = FILL_WORD[DATA_W-1:0];
    end
  endgenerate

  assign r_valid = rv_q;
  assign r_id    = rid_q;
  assign r_resp  = rresp_q;
  assign r_last  = rlast_q;

  assert_r_hold_R10: assert property (@(posedge clk) disable iff (rst)
    r_valid && !r_ready |=> r_valid && $stable(r_id) && $stable(r_last) && $stable(r_resp));
  assert_burst_no_gap_R3: assert property (@(posedge clk) disable iff (rst)
    r_valid && r_ready && !r_last |=> r_valid && $stable(r_id));
  assert_rresp_code_R2: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> r_resp == RESP_DECERR);
endmodule

// File: rtl/axi_decerr_sink.sv
module axi_decerr_sink #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  decerr_wr_path #(.ID_W(ID_W), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp)
  );

  decerr_rd_path #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last)
  );

  // R1: no response is offered in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !b_valid && !r_valid);
endmodule

// File: tb/tb_axi_decerr_sink.sv
module tb_axi_decerr_sink;
  localparam int ID_W = 4, LEN_W = 8, DW = 64, DEPTH = 4;
  localparam logic [DW-1:0] EXP_DATA = {{(DW-32){1'b0}}, 32'hBADCAB1E};

  logic clk = 0, rst = 1;
  logic aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
  logic [ID_W-1:0] aw_id = 0, ar_id = 0;
  logic [LEN_W-1:0] ar_len = 0;
  logic aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
  logic [ID_W-1:0] b_id, r_id;
  logic [1:0] b_resp, r_resp;
  logic [DW-1:0] r_data;

  axi_decerr_sink #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0, mode = 1;
  bit checking = 0, done = 0;

  typedef struct { int id; bit last; } beat_t;
  int awq[$];
  int bq[$];
  beat_t rq[$];
  int ar_out = 0;
  bit prev_rstall = 0, prev_bstall = 0;
  int prev_rid = 0, prev_bid = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    case (mode)
      0: begin r_ready <= 0; b_ready <= 0; end
      1: begin r_ready <= 1; b_ready <= 1; end
      default: begin r_ready <= 1'($urandom % 2); b_ready <= 1'($urandom % 2); end
    endcase
  end

  // Behavioural reference model, compared on every clock
  always @(negedge clk) begin
    if (checking && !rst) begin
      chk(aw_ready == (awq.size() < DEPTH), "R9", "aw_ready", aw_ready, awq.size() < DEPTH);
      chk(w_ready == (awq.size() > 0 && bq.size() == 0), "R8", "w_ready", w_ready,
          awq.size() > 0 && bq.size() == 0);
      chk(b_valid == (bq.size() > 0), "R5", "b_valid", b_valid, bq.size() > 0);
      if (b_valid && bq.size() > 0) begin
        chk(b_id == ID_W'(bq[0]), "R6", "b_id", b_id, bq[0]);
        chk(b_resp == 2'b11, "R2", "b_resp", b_resp, 3);
      end
      if (ar_out < DEPTH) chk(ar_ready == 1'b1, "R9", "ar_ready", ar_ready, 1);
      if (rq.size() == 0) chk(r_valid == 1'b0, "R3", "r_valid with no beat due", r_valid, 0);
      if (r_valid && rq.size() > 0) begin
        chk(r_id == ID_W'(rq[0].id), "R6", "r_id", r_id, rq[0].id);
        chk(r_last == rq[0].last, "R3", "r_last", r_last, rq[0].last);
        chk(r_data == EXP_DATA, "R4", "r_data low word", int'(r_data[31:0]), int'(EXP_DATA[31:0]));
        chk(r_data[DW-1:32] == '0, "R4", "r_data upper zero", int'(r_data[DW-1:32]), 0);
        chk(r_resp == 2'b11, "R2", "r_resp", r_resp, 3);
      end
      if (prev_rstall) chk(r_valid && r_id == ID_W'(prev_rid), "R10", "r held", r_valid, 1);
      if (prev_bstall) chk(b_valid && b_id == ID_W'(prev_bid), "R10", "b held", b_valid, 1);
      prev_rstall = r_valid && !r_ready; prev_rid = r_id;
      prev_bstall = b_valid && !b_ready; prev_bid = b_id;
      if (aw_valid && aw_ready) awq.push_back(int'(aw_id));
      if (b_valid && b_ready && bq.size() > 0) void'(bq.pop_front());
      if (w_valid && w_ready && w_last && awq.size() > 0) bq.push_back(awq.pop_front());
      if (ar_valid && ar_ready) begin
        for (int i = 0; i <= int'(ar_len); i++) rq.push_back('{int'(ar_id), i == int'(ar_len)});
        ar_out++;
      end
      if (r_valid && r_ready && rq.size() > 0) begin
        if (rq[0].last) ar_out--;
        void'(rq.pop_front());
      end
    end
  end

  task automatic send_aw(int id);
    aw_valid = 1; aw_id = ID_W'(id);
    do @(negedge clk); while (!aw_ready);
    @(posedge clk); #1; aw_valid = 0;
  endtask

  task automatic send_w(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      w_valid = 1; w_last = (i == n - 1);
      do @(negedge clk); while (!w_ready);
      @(posedge clk); #1; w_valid = 0; w_last = 0;
      if (gaps && ($urandom % 2)) begin @(posedge clk); #1; end
    end
  endtask

  task automatic send_ar(int id, int len);
    ar_valid = 1; ar_id = ID_W'(id); ar_len = LEN_W'(len);
    do @(negedge clk); while (!ar_ready);
    @(posedge clk); #1; ar_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((awq.size() || bq.size() || rq.size()) && n < 20000) begin @(posedge clk); n++; end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!b_valid && !r_valid && !w_ready, "R1", "valids in reset", {b_valid, r_valid, w_ready}, 0);
    @(posedge clk); #1; rst = 0;
    @(negedge clk);
    chk(aw_ready && ar_ready, "R1", "readies after reset", {aw_ready, ar_ready}, 3);
    chk(!b_valid && !r_valid && !w_ready, "R1", "idle after reset", {b_valid, r_valid, w_ready}, 0);
    checking = 1;
    @(posedge clk); #1;

    // single-beat write and zero-length read (R3, R5, R6)
    send_aw(1); send_w(1, 0); send_ar(2, 0);
    wait_idle();

    // W offered before its AW must be held off (R8)
    fork
      send_w(3, 0);
      begin repeat (6) @(posedge clk); #1; send_aw(5); end
    join
    wait_idle();

    // bursts under random backpressure (R3, R10)
    mode = 2;
    fork
      begin send_ar(3, 3); send_ar(4, 7); send_ar(6, 0); send_ar(7, 255); send_ar(8, 0); end
      begin send_aw(9); send_w(4, 1); send_aw(10); send_w(2, 1); end
    join
    wait_idle();

    // fill both queues with responses stalled (R9, R7)
    mode = 0;
    fork
      for (int i = 0; i < 6; i++) send_ar(i, i % 3);
      for (int i = 0; i < 6; i++) send_aw(15 - i);
      begin repeat (40) @(posedge clk); #1; mode = 1; end
      begin repeat (45) @(posedge clk); #1; for (int i = 0; i < 6; i++) send_w(i % 3 + 1, 0); end
    join
    wait_idle();

    // back-to-back zero-length reads with ready held high (R3, R7)
    fork
      for (int i = 0; i < 8; i++) send_ar(i, 0);
    join
    wait_idle();

    // concurrent random traffic (R7)
    mode = 2;
    fork
      for (int i = 0; i < 30; i++) send_ar(int'($urandom % 16), int'($urandom % 12));
      for (int i = 0; i < 30; i++) begin send_aw(int'($urandom % 16)); send_w(int'($urandom % 5) + 1, 1); end
    join
    wait_idle();
    mode = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!r_valid && !b_valid, "R7", "all responses drained", {r_valid, b_valid}, 0);
    done = 1;
    finish_run();
  end
endmodule